// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a small 32-bit processor core. It offers sixteen logical registers through two combinational read ports and one clocked write port. Which physical word a logical index selects depends on the current processor mode. The five exception modes each swap in private copies of some registers. In the fast-interrupt mode a wider span is swapped, from index 7 up to index 14. User and System modes work on one shared set. Index 15 is the program counter, which lives outside the block. Reads of index 15 return the external PC value, and writes to index 15 become a branch request.

The block also keeps the current status word and one saved status word for each exception mode. A dedicated exception-entry port stores a return address into the target mode's private link register. On the same clock edge it copies the current status word into that mode's saved status word. The mode itself is an input driven by the surrounding control logic. Mode codes are USR=0, SYS=1, FIQ=2, IRQ=3, SVC=4, ABT=5, UND=6, and code 7 acts as a user-class mode.

Top module: `banked_regfile`

## Requirements
- R1: Reads of indices 0 to 14 return the stored word combinationally in the same cycle. A read of index 15 returns `pc_i`.
- R2: A write takes effect at the rising clock edge. A read of the same physical word in the same cycle returns the old value.
- R3: In modes IRQ (3), SVC (4), ABT (5) and UND (6), indices 13 and 14 select a pair of words private to that mode. All other indices select the shared words.
- R4: In mode FIQ (2), indices 7 to 14 select eight words private to that mode. Indices 0 to 6 stay shared.
- R5: Modes USR (0), SYS (1) and code 7 all see the same unbanked words for indices 0 to 14.
- R6: A write to index 15 changes no stored word. In the next cycle it sets `branch_req_o` to 1 and `branch_addr_o` to the written data. In any other cycle `branch_req_o` is 0.
- R7: `cpsr_o` takes `cpsr_wdata_i` one cycle after `cpsr_we_i` and holds its value otherwise.
- R8: `spsr_o` shows the saved status word of the current mode. In modes 0, 1 and 7 it reads 0, and `spsr_we_i` is ignored.
- R9: When `exc_en_i` is set and `exc_mode_i` is an exception mode (2 to 6), one edge writes `exc_link_i` into that mode's index-14 word and the current `cpsr_o` into that mode's saved status word. When `exc_mode_i` is 0, 1 or 7, the request is ignored.
- R10: An exception entry wins over a same-cycle `wr_en_i` or `spsr_we_i` that targets the same physical word.
- R11: After reset, all stored words and status words are 0 and `branch_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Current processor mode code |
| pc_i | input | XLEN | External program counter value |
| rd_a_idx_i | input | 4 | Read port A logical index |
| rd_a_data_o | output | XLEN | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical index |
| rd_b_data_o | output | XLEN | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write logical index |
| wr_data_i | input | XLEN | Write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | XLEN | Current status write data |
| cpsr_o | output | XLEN | Current status word |
| spsr_we_i | input | 1 | Saved status write enable (current mode) |
| spsr_wdata_i | input | XLEN | Saved status write data |
| spsr_o | output | XLEN | Saved status word of current mode |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_mode_i | input | 3 | Mode being entered |
| exc_link_i | input | XLEN | Return address for the banked link word |
| branch_req_o | output | 1 | Registered branch request from a write to index 15 |
| branch_addr_o | output | XLEN | Branch target captured with the request |

## Verification
Read data and `spsr_o` are combinational, so they are due in the same cycle as the index and mode that select them. The bench samples them 5 ns after it drives inputs on the falling edge, which is before the next rising edge commits any write. Stored words, `cpsr_o`, the saved status words and the branch outputs change at the rising edge, so their results are due one cycle after the stimulus. Each expected item in the scoreboard carries the window in which it is due, and the monitor compares it only in that window. This timing also exposes the read-before-write behaviour, because a read issued in the same cycle as a write is sampled before that write commits.

// File: rtl/bregs_pkg.sv
package bregs_pkg;
  localparam int NLOG       = 16;
  localparam int IDXW       = $clog2(NLOG);
  localparam int NCOMMON    = NLOG - 1;        // index 15 is not stored
  localparam int FIQ_LO     = 7;
  localparam int NFIQ       = NCOMMON - FIQ_LO; // 7..14
  localparam int NPAIR      = 2;                // 13,14
  localparam int NSMALL     = 4;                // IRQ,SVC,ABT,UND
  localparam int FIQ_BASE   = NCOMMON;
  localparam int SMALL_BASE = FIQ_BASE + NFIQ;
  localparam int NPHYS      = SMALL_BASE + NPAIR * NSMALL;
  localparam int PW         = $clog2(NPHYS);
  localparam int NSAVED     = NSMALL + 1;

  typedef enum logic [2:0] {
    MD_USR = 3'd0, MD_SYS = 3'd1, MD_FIQ = 3'd2, MD_IRQ = 3'd3,
    MD_SVC = 3'd4, MD_ABT = 3'd5, MD_UND = 3'd6, MD_RSV = 3'd7
  } mode_e;

  function automatic logic is_exc_mode(logic [2:0] m);
    return (m >= 3'd2) && (m <= 3'd6);
  endfunction

  // FIQ=0, IRQ=1, SVC=2, ABT=3, UND=4
  function automatic logic [2:0] saved_slot(logic [2:0] m);
    return m - 3'd2;
  endfunction
endpackage

// File: rtl/bregs_map.sv
module bregs_map
  import bregs_pkg::*;
(
  input  logic [2:0]      mode,
  input  logic [IDXW-1:0] idx,
  output logic [PW-1:0]   phys,
  output logic            is_pc
);
  logic [1:0] bank;

  always_comb begin
    unique case (mode)
      MD_SVC:  bank = 2'd1;
      MD_ABT:  bank = 2'd2;
      MD_UND:  bank = 2'd3;
      default: bank = 2'd0;
    endcase
  end

  always_comb begin
    is_pc = (idx == IDXW'(NLOG - 1));
    phys  = PW'(idx);
    if (mode == MD_FIQ && idx >= IDXW'(FIQ_LO) && !is_pc) begin
      phys = PW'(FIQ_BASE) + PW'(idx - IDXW'(FIQ_LO));
    end else if (mode inside {MD_IRQ, MD_SVC, MD_ABT, MD_UND} &&
                 idx >= IDXW'(NLOG - 1 - NPAIR) && !is_pc) begin
      phys = PW'(SMALL_BASE) + PW'(NPAIR) * PW'(bank)
           + PW'(idx - IDXW'(NLOG - 1 - NPAIR));
    end
  end
endmodule

// File: rtl/bregs_store.sv
module bregs_store
  import bregs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic            xe,
  input  logic [PW-1:0]   xaddr,
  input  logic [XLEN-1:0] xdata,
  input  logic [PW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [PW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data
);
  logic [XLEN-1:0] mem_q [NPHYS];
  logic [XLEN-1:0] mem_d [NPHYS];
  logic [NPHYS-1:0] mem_en;

  for (genvar g = 0; g < NPHYS; g++) begin : g_word
    // exception entry has priority on the shared word
    always_comb begin
      mem_en[g] = 1'b0;
      mem_d[g]  = mem_q[g];
      if (xe && xaddr == PW'(g)) begin
        mem_en[g] = 1'b1;
        mem_d[g]  = xdata;
      end else if (we && waddr == PW'(g)) begin
        mem_en[g] = 1'b1;
        mem_d[g]  = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[g] <= '0;
      else if (mem_en[g]) mem_q[g] <= mem_d[g];
    end
  end

  assign ra_data = (int'(ra_addr) < NPHYS) ? mem_q[ra_addr] : '0;
  assign rb_data = (int'(rb_addr) < NPHYS) ? mem_q[rb_addr] : '0;
endmodule

// File: rtl/bregs_status.sv
module bregs_status
  import bregs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cur_mode,
  input  logic            cpsr_we,
  input  logic [XLEN-1:0] cpsr_wdata,
  input  logic            spsr_we,
  input  logic [XLEN-1:0] spsr_wdata,
  input  logic            xe,
  input  logic [2:0]      xmode,
  output logic [XLEN-1:0] cpsr,
  output logic [XLEN-1:0] spsr
);
  logic [XLEN-1:0] cpsr_q, cpsr_d;
  logic [XLEN-1:0] sv_q [NSAVED];
  logic [XLEN-1:0] sv_d [NSAVED];
  logic [NSAVED-1:0] sv_en;
  logic cur_ok, x_ok;
  logic [2:0] cur_slot, x_slot;

  assign cur_ok   = is_exc_mode(cur_mode);
  assign x_ok     = xe && is_exc_mode(xmode);
  assign cur_slot = saved_slot(cur_mode);
  assign x_slot   = saved_slot(xmode);
  assign cpsr_d   = cpsr_we ? cpsr_wdata : cpsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpsr_q <= '0;
    else        cpsr_q <= cpsr_d;
  end

  for (genvar s = 0; s < NSAVED; s++) begin : g_saved
    always_comb begin
      sv_en[s] = 1'b0;
      sv_d[s]  = sv_q[s];
      if (x_ok && x_slot == 3'(s)) begin
        sv_en[s] = 1'b1;
        sv_d[s]  = cpsr_q;
      end else if (spsr_we && cur_ok && cur_slot == 3'(s)) begin
        sv_en[s] = 1'b1;
        sv_d[s]  = spsr_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sv_q[s] <= '0;
      else if (sv_en[s]) sv_q[s] <= sv_d[s];
    end
  end

  assign cpsr = cpsr_q;
  assign spsr = cur_ok ? sv_q[cur_slot] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [3:0]      rd_a_idx_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [3:0]      rd_b_idx_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [3:0]      wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            cpsr_we_i,
  input  logic [XLEN-1:0] cpsr_wdata_i,
  output logic [XLEN-1:0] cpsr_o,
  input  logic            spsr_we_i,
  input  logic [XLEN-1:0] spsr_wdata_i,
  output logic [XLEN-1:0] spsr_o,
  input  logic            exc_en_i,
  input  logic [2:0]      exc_mode_i,
  input  logic [XLEN-1:0] exc_link_i,
  output logic            branch_req_o,
  output logic [XLEN-1:0] branch_addr_o
);
  localparam int NMAP = 4; // read A, read B, write, exception link
  localparam int M_RA = 0, M_RB = 1, M_WR = 2, M_EX = 3;

  logic [2:0]      map_mode [NMAP];
  logic [IDXW-1:0] map_idx  [NMAP];
  logic [PW-1:0]   map_phys [NMAP];
  logic [NMAP-1:0] map_pc;

  assign map_mode[M_RA] = mode_i;     assign map_idx[M_RA] = rd_a_idx_i;
  assign map_mode[M_RB] = mode_i;     assign map_idx[M_RB] = rd_b_idx_i;
  assign map_mode[M_WR] = mode_i;     assign map_idx[M_WR] = wr_idx_i;
  assign map_mode[M_EX] = exc_mode_i; assign map_idx[M_EX] = IDXW'(NLOG - 2);

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    bregs_map u_map (
      .mode  (map_mode[m]),
      .idx   (map_idx[m]),
      .phys  (map_phys[m]),
      .is_pc (map_pc[m])
    );
  end

  logic            exc_ok;
  logic [XLEN-1:0] ra_word, rb_word;

  assign exc_ok = exc_en_i && is_exc_mode(exc_mode_i);

  bregs_store #(.XLEN(XLEN)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en_i && !map_pc[M_WR]),
    .waddr   (map_phys[M_WR]),
    .wdata   (wr_data_i),
    .xe      (exc_ok),
    .xaddr   (map_phys[M_EX]),
    .xdata   (exc_link_i),
    .ra_addr (map_phys[M_RA]),
    .ra_data (ra_word),
    .rb_addr (map_phys[M_RB]),
    .rb_data (rb_word)
  );

  assign rd_a_data_o = map_pc[M_RA] ? pc_i : ra_word;
  assign rd_b_data_o = map_pc[M_RB] ? pc_i : rb_word;

  bregs_status #(.XLEN(XLEN)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_mode   (mode_i),
    .cpsr_we    (cpsr_we_i),
    .cpsr_wdata (cpsr_wdata_i),
    .spsr_we    (spsr_we_i),
    .spsr_wdata (spsr_wdata_i),
    .xe         (exc_en_i),
    .xmode      (exc_mode_i),
    .cpsr       (cpsr_o),
    .spsr       (spsr_o)
  );

  // branch request from a write to the program counter
  logic            br_req_q, br_req_d;
  logic [XLEN-1:0] br_addr_q, br_addr_d;
  logic            br_addr_en;

  always_comb begin
    br_req_d   = wr_en_i && map_pc[M_WR];
    br_addr_en = br_req_d;
    br_addr_d  = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) br_req_q <= 1'b0;
    else        br_req_q <= br_req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          br_addr_q <= '0;
    else if (br_addr_en) br_addr_q <= br_addr_d;
  end

  assign branch_req_o  = br_req_q;
  assign branch_addr_o = br_addr_q;
endmodule

// File: rtl/bregs_chk.sv
module bregs_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      mode_i,
  input logic [XLEN-1:0] pc_i,
  input logic [3:0]      rd_a_idx_i,
  input logic [XLEN-1:0] rd_a_data_o,
  input logic            wr_en_i,
  input logic [3:0]      wr_idx_i,
  input logic [XLEN-1:0] wr_data_i,
  input logic            cpsr_we_i,
  input logic [XLEN-1:0] cpsr_wdata_i,
  input logic [XLEN-1:0] cpsr_o,
  input logic [XLEN-1:0] spsr_o,
  input logic            exc_en_i,
  input logic [2:0]      exc_mode_i,
  input logic [XLEN-1:0] exc_link_i,
  input logic            branch_req_o,
  input logic [XLEN-1:0] branch_addr_o
);
  // R1
  pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx_i == 4'd15 |-> rd_a_data_o == pc_i);

  // R6
  branch_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 4'd15) |=>
      (branch_req_o && branch_addr_o == $past(wr_data_i)));

  // R6
  branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_idx_i == 4'd15) |=> !branch_req_o);

  // R7
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we_i |=> cpsr_o == $past(cpsr_wdata_i));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_we_i |=> $stable(cpsr_o));

  // R8
  user_saved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i inside {3'd0, 3'd1, 3'd7}) |-> spsr_o == '0);

  // R9
  entry_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en_i && exc_mode_i >= 3'd2 && exc_mode_i <= 3'd6) ##1
      (mode_i == $past(exc_mode_i)) |-> spsr_o == $past(cpsr_o));

  // R9
  entry_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en_i && exc_mode_i >= 3'd2 && exc_mode_i <= 3'd6) ##1
      (mode_i == $past(exc_mode_i) && rd_a_idx_i == 4'd14)
      |-> rd_a_data_o == $past(exc_link_i));
endmodule

bind banked_regfile bregs_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam int XLEN = 32;
  localparam int S_RA = 0, S_RB = 1, S_CPSR = 2, S_SPSR = 3, S_BREQ = 4, S_BADDR = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      mode_i;
  logic [XLEN-1:0] pc_i;
  logic [3:0]      rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [XLEN-1:0] rd_a_data_o, rd_b_data_o, wr_data_i;
  logic            wr_en_i, cpsr_we_i, spsr_we_i, exc_en_i;
  logic [XLEN-1:0] cpsr_wdata_i, cpsr_o, spsr_wdata_i, spsr_o;
  logic [2:0]      exc_mode_i;
  logic [XLEN-1:0] exc_link_i, branch_addr_o;
  logic            branch_req_o;

  always #10 clk = ~clk;

  banked_regfile #(.XLEN(XLEN)) dut_i (.*);

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int ncyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  function automatic logic [31:0] probe(int sel);
    case (sel)
      S_RA:    return rd_a_data_o;
      S_RB:    return rd_b_data_o;
      S_CPSR:  return cpsr_o;
      S_SPSR:  return spsr_o;
      S_BREQ:  return {31'b0, branch_req_o};
      default: return branch_addr_o;
    endcase
  endfunction

  task automatic expect_at(int dly, int sel, logic [31:0] v, string tag);
    item_t it;
    it.due = ncyc + dly; it.sel = sel; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: one window per falling edge, sampled 5 ns later
  initial begin
    forever begin
      @(negedge clk);
      #5;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == ncyc) begin
          logic [31:0] got;
          got = probe(sb[i].sel);
          compared++;
          if (got !== sb[i].exp) begin
            mismatched++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", sb[i].tag,
                     sb[i].sel, got, sb[i].exp);
          end
          sb.delete(i);
        end
      end
      ncyc++;
    end
  end

  task automatic step(logic [2:0] md);
    @(negedge clk);
    mode_i    = md;
    wr_en_i   = 1'b0; cpsr_we_i = 1'b0; spsr_we_i = 1'b0; exc_en_i = 1'b0;
    rd_a_idx_i = 4'd0; rd_b_idx_i = 4'd0;
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] d);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_i = 3'd0; pc_i = 32'h1000;
    rd_a_idx_i = 0; rd_b_idx_i = 0; wr_idx_i = 0; wr_data_i = 0;
    wr_en_i = 0; cpsr_we_i = 0; spsr_we_i = 0; exc_en_i = 0;
    cpsr_wdata_i = 0; spsr_wdata_i = 0; exc_mode_i = 0; exc_link_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R11) and PC read (R1)
    step(3'd0); rd_a_idx_i = 4'd3; rd_b_idx_i = 4'd15;
    expect_at(0, S_RA, 32'h0, "R11 word zero");
    expect_at(0, S_RB, 32'h1000, "R1 pc read");
    expect_at(0, S_CPSR, 32'h0, "R11 cpsr zero");
    expect_at(0, S_BREQ, 32'h0, "R11 no branch");

    // user writes, read-before-write (R2)
    step(3'd0); wr(4'd13, 32'hA013); rd_a_idx_i = 4'd13;
    expect_at(0, S_RA, 32'h0, "R2 old value same cycle");
    step(3'd0); wr(4'd14, 32'hA014); rd_a_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hA013, "R2 write visible");
    step(3'd0); wr(4'd7, 32'hA007); rd_a_idx_i = 4'd14;
    expect_at(0, S_RA, 32'hA014, "R1 stored read");

    // supervisor bank (R3)
    step(3'd4); wr(4'd13, 32'h5113); rd_a_idx_i = 4'd7; rd_b_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hA007, "R3 shared r7 in svc");
    expect_at(0, S_RB, 32'h0, "R3 private r13 svc");
    step(3'd4); wr(4'd0, 32'hC000); rd_a_idx_i = 4'd13; rd_b_idx_i = 4'd14;
    expect_at(0, S_RA, 32'h5113, "R3 svc r13 write");
    expect_at(0, S_RB, 32'h0, "R3 svc r14 private");

    // fast-interrupt bank (R4)
    step(3'd2); wr(4'd7, 32'hF007); rd_a_idx_i = 4'd7; rd_b_idx_i = 4'd0;
    expect_at(0, S_RA, 32'h0, "R4 fiq r7 private");
    expect_at(0, S_RB, 32'hC000, "R4 fiq r0 shared");
    step(3'd2); rd_a_idx_i = 4'd7; rd_b_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hF007, "R4 fiq r7 write");
    expect_at(0, S_RB, 32'h0, "R4 fiq r13 private");

    // system shares user set (R5)
    step(3'd1); rd_a_idx_i = 4'd7; rd_b_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hA007, "R5 sys r7");
    expect_at(0, S_RB, 32'hA013, "R5 sys r13");

    // irq and undefined banks (R3)
    step(3'd3); rd_a_idx_i = 4'd13; rd_b_idx_i = 4'd14;
    expect_at(0, S_RA, 32'h0, "R3 irq r13 private");
    expect_at(0, S_RB, 32'h0, "R3 irq r14 private");
    step(3'd6); wr(4'd14, 32'hD014); rd_a_idx_i = 4'd14;
    expect_at(0, S_RA, 32'h0, "R3 und r14 before");
    step(3'd6); rd_a_idx_i = 4'd14; rd_b_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hD014, "R3 und r14 write");
    expect_at(0, S_RB, 32'h0, "R3 und r13 private");

    // status words (R7, R8)
    step(3'd0); cpsr_we_i = 1'b1; cpsr_wdata_i = 32'h10;
    spsr_we_i = 1'b1; spsr_wdata_i = 32'hBAD;
    expect_at(0, S_SPSR, 32'h0, "R8 user saved reads zero");
    expect_at(1, S_CPSR, 32'h10, "R7 cpsr load");
    step(3'd4); exc_en_i = 1'b1; exc_mode_i = 3'd3; exc_link_i = 32'h1E14;
    expect_at(0, S_SPSR, 32'h0, "R8 user write ignored");

    // exception entry into irq (R9)
    step(3'd3); rd_a_idx_i = 4'd14; spsr_we_i = 1'b1; spsr_wdata_i = 32'h55;
    expect_at(0, S_RA, 32'h1E14, "R9 link written");
    expect_at(0, S_SPSR, 32'h10, "R9 saved status");
    step(3'd3); rd_a_idx_i = 4'd14;
    exc_en_i = 1'b1; exc_mode_i = 3'd3; exc_link_i = 32'h2E14;
    spsr_we_i = 1'b1; spsr_wdata_i = 32'h77; wr(4'd14, 32'h99);
    expect_at(0, S_SPSR, 32'h55, "R8 saved write in irq");
    expect_at(0, S_RA, 32'h1E14, "R2 old link same cycle");
    step(3'd3); rd_a_idx_i = 4'd14;
    exc_en_i = 1'b1; exc_mode_i = 3'd1; exc_link_i = 32'hDEAD;
    expect_at(0, S_RA, 32'h2E14, "R10 entry beats write");
    expect_at(0, S_SPSR, 32'h10, "R10 entry beats saved write");
    step(3'd0); rd_a_idx_i = 4'd14; rd_b_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hA014, "R9 non-exception entry ignored");
    expect_at(0, S_RB, 32'hA013, "R9 user r13 intact");
    expect_at(0, S_CPSR, 32'h10, "R7 cpsr held");

    // program counter write (R6)
    step(3'd0); pc_i = 32'h2000; wr(4'd15, 32'h8000); rd_a_idx_i = 4'd15;
    expect_at(0, S_RA, 32'h2000, "R1 pc read");
    expect_at(0, S_BREQ, 32'h0, "R6 no request yet");
    expect_at(1, S_BREQ, 32'h1, "R6 request raised");
    expect_at(1, S_BADDR, 32'h8000, "R6 branch target");
    step(3'd0);
    expect_at(1, S_BREQ, 32'h0, "R6 request drops");

    // entry into fiq (R9, R4)
    step(3'd0); exc_en_i = 1'b1; exc_mode_i = 3'd2; exc_link_i = 32'hF014;
    step(3'd2); rd_a_idx_i = 4'd14; rd_b_idx_i = 4'd7;
    expect_at(0, S_RA, 32'hF014, "R9 fiq link");
    expect_at(0, S_RB, 32'hF007, "R4 fiq r7 kept");
    expect_at(0, S_SPSR, 32'h10, "R9 fiq saved status");

    // code 7 behaves as user (R5, R8)
    step(3'd7); rd_a_idx_i = 4'd7; rd_b_idx_i = 4'd13;
    expect_at(0, S_RA, 32'hA007, "R5 code7 r7");
    expect_at(0, S_RB, 32'hA013, "R5 code7 r13");
    expect_at(0, S_SPSR, 32'h0, "R8 code7 saved zero");

    repeat (3) step(3'd0);
    if (sb.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: %0d items never compared", sb.size());
    end
    finish_run();
  end
endmodule